// File: doc/BRIEF.md
# Serial Clock Generator with Multi-Master Synchronization

This block generates the bit clock of a two-wire serial unit. A reloadable down-counter divides the system clock into low and high half-periods. The block drives the clock line open-drain: it can pull the line low or release it, and it never drives the line high. A request starts one frame of nine clock pulses. The block counts the pulses and then releases the line and goes back to idle. The downstream shift logic gets an effective shift clock. This clock is the AND of the internal clock and the synchronized line level.

Three optional behaviours sit on top of the divider:

- **Wired-AND synchronization.** This mode applies only when the internal clock source is selected. Another master can shorten the high phase by pulling the line low. A master that holds the line low stalls the high phase until the line is seen high again.
- **Clock stretching.** The block can hold the line low after the eighth pulse, to leave time for address comparison and acknowledge generation. It can also hold the line low after the ninth (acknowledge) pulse.
- **Stop release.** When a stop condition from another master is reported during a frame, the block can release the line and stop generating clocks.

The controller has six states:

| State | Line | Internal clock | What it does |
|---|---|---|---|
| IDLE | released | high | Waits for a request. |
| LOW | pulled low | low | Counts the low half-period. |
| WAIT_HI | released | high | Synchronization mode only. Waits for the line to be seen high. |
| HIGH | released | high | Counts the high half-period. |
| HOLD_DATA | pulled low | low | Stretches after the eighth pulse. |
| HOLD_ACK | pulled low | low | Stretches after the ninth pulse. |

The transitions are:

- **start**: IDLE to LOW, on a request.
- **low_done**:
  - LOW to HIGH when the count expires without synchronization.
  - LOW to WAIT_HI when the count expires with synchronization and the line is seen low.
- **line_high**: WAIT_HI to HIGH.
- **high_done**: the count expires, or a falling edge arrives with synchronization. It leads to one of four places:
  - LOW after pulses 1 to 7.
  - LOW after pulse 8 without stretching.
  - HOLD_DATA after pulse 8 with stretching.
  - HOLD_ACK or IDLE after pulse 9.
- **data_resume**: HOLD_DATA to LOW.
- **ack_resume**: HOLD_ACK to IDLE.
- **stop_abort**: any state other than IDLE to IDLE.

Top module: `sclgen_top`

## Requirements
- R1: After reset, and whenever the controller is idle, `scl_pull_low` is 0 and `bit_cnt` is 0. With the line high, `shift_clk` is 1.
- R2: Without synchronization, a frame has nine pulses. Before each pulse the line is pulled low for reload+1 cycles, and each pulse is released for reload+1 cycles. The frame then ends with the line released.
- R3: With synchronization active and no other master on the line, each low phase lasts max(reload+1, 3) cycles. Each released phase lasts reload+4 cycles: 3 cycles of synchronizer latency plus reload+1 counted cycles.
- R4: With synchronization active, when the line falls during a high phase, `scl_pull_low` rises on the third clock edge after the fall. The counter reloads and a full low phase is counted.
- R5: With synchronization active, the high phase does not count while the line is held low by another master. `scl_pull_low` rises again reload+4 clock edges after the line is released.
- R6: Synchronization has no effect when `sync_en` is 0 or when `int_src` is 0 (external clock source). In that case the timing is that of R2, and a line fall during a high phase does not shorten it.
- R7: `shift_clk` is the internal clock ANDed with the synchronized line. It is 0 while the block has released the line but another master still holds it low.
- R8: `bit_cnt` increments by one each time the block releases the line for a pulse, counting 1 to 9. It never exceeds 9 and returns to 0 when the ninth pulse ends.
- R9: With `hold_data_en` set, the line stays pulled low after the eighth pulse with `bit_cnt` = 8. Clearing the control resumes with a low phase and then the ninth pulse.
- R10: With `hold_ack_en` set, the line stays pulled low after the ninth pulse with `bit_cnt` = 9. Clearing the control releases the line and returns `bit_cnt` to 0 on the next clock edge.
- R11: With `stop_rel_en` set, `stop_seen` during a frame releases the line and clears `bit_cnt` on the next clock edge, and no further pulses follow.
- R12: With `stop_rel_en` clear, `stop_seen` is ignored and the frame completes all nine pulses.
- R13: While idle, activity on the line from another master neither pulls the line nor changes `bit_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw clock-line level, asynchronous |
| reload | input | CNT_W | Half-period reload value |
| int_src | input | 1 | 1 = internal clock source selected |
| sync_en | input | 1 | Wired-AND synchronization enable |
| hold_data_en | input | 1 | Stretch after the eighth pulse |
| hold_ack_en | input | 1 | Stretch after the ninth pulse |
| stop_rel_en | input | 1 | Release the line on a foreign stop |
| xfer_req | input | 1 | Start a frame (sampled while idle) |
| stop_seen | input | 1 | Stop condition detected on the bus |
| scl_pull_low | output | 1 | Open-drain enable: 1 pulls the line low |
| shift_clk | output | 1 | Effective shift clock |
| bit_cnt | output | BIT_W | Pulse number within the frame, 0 when idle |

## Verification
The bench builds the block with its defaults: CNT_W = 4, BITS = 9 and SYNC_STAGES = 2. With these values the sweeps can cover every reload value from 0 to 15, both with and without synchronization, and each run measures all eighteen half-periods of a frame. The shortest reloads exercise the three-cycle floor that synchronizer latency puts on the low phase. A reload of 10 leaves room to inject a foreign pull-down in the middle of a high phase and to observe the stall and the restart edge by edge.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_WAIT_HI,
        ST_HIGH,
        ST_HOLD_DATA,
        ST_HOLD_ACK
    } scl_state_t;
endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pin_s,
    output logic pin_fall
);
    logic [STAGES-1:0] shreg;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '1;
            prev_q <= 1'b1;
        end else begin
            shreg  <= {shreg[STAGES-2:0], pin};
            prev_q <= shreg[STAGES-1];
        end
    end

    assign pin_s    = shreg[STAGES-1];
    assign pin_fall = prev_q & ~shreg[STAGES-1];
endmodule

// File: rtl/sclgen_baud.sv
module sclgen_baud #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload,
    input  logic         load,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
    import sclgen_pkg::*;
#(
    parameter int BITS  = 9,
    parameter int BIT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_req,
    input  logic             stop_seen,
    input  logic             stop_rel_en,
    input  logic             sync_act,
    input  logic             hold_data_en,
    input  logic             hold_ack_en,
    input  logic             pin_s,
    input  logic             pin_fall,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic             cnt_dec,
    output logic             pull_low,
    output logic             int_clk,
    output logic [BIT_W-1:0] bit_cnt
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS);
    localparam logic [BIT_W-1:0] DATA_BIT = BIT_W'(BITS - 1);

    scl_state_t       state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic             bit_inc;
    logic             high_end;
    logic             stop_hit;

    assign stop_hit = stop_rel_en && stop_seen && (state_q != ST_IDLE);
    assign high_end = cnt_zero || (sync_act && pin_fall);

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        bit_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_req) begin
                    state_d  = ST_LOW;
                    cnt_load = 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt_zero && (!sync_act || !pin_s)) begin
                    state_d  = sync_act ? ST_WAIT_HI : ST_HIGH;
                    cnt_load = 1'b1;
                    bit_inc  = 1'b1;
                end
            end
            ST_WAIT_HI: begin
                if (pin_s) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (high_end) begin
                    if (bit_q == LAST_BIT) begin
                        state_d = hold_ack_en ? ST_HOLD_ACK : ST_IDLE;
                    end else if ((bit_q == DATA_BIT) && hold_data_en) begin
                        state_d = ST_HOLD_DATA;
                    end else begin
                        state_d  = ST_LOW;
                        cnt_load = 1'b1;
                    end
                end
            end
            ST_HOLD_DATA: begin
                if (!hold_data_en) begin
                    state_d  = ST_LOW;
                    cnt_load = 1'b1;
                end
            end
            ST_HOLD_ACK: begin
                if (!hold_ack_en) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (stop_hit) begin
            state_d  = ST_IDLE;
            cnt_load = 1'b0;
            bit_inc  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_IDLE) begin
                bit_q <= '0;
            end else if (bit_inc) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        pull_low = 1'b0;
        int_clk  = 1'b1;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE:      begin pull_low = 1'b0; int_clk = 1'b1; end
            ST_LOW:       begin pull_low = 1'b1; int_clk = 1'b0; cnt_dec = 1'b1; end
            ST_WAIT_HI:   begin pull_low = 1'b0; int_clk = 1'b1; end
            ST_HIGH:      begin pull_low = 1'b0; int_clk = 1'b1; cnt_dec = 1'b1; end
            ST_HOLD_DATA: begin pull_low = 1'b1; int_clk = 1'b0; end
            ST_HOLD_ACK:  begin pull_low = 1'b1; int_clk = 1'b0; end
            default:      begin pull_low = 1'b0; int_clk = 1'b1; end
        endcase
    end

    assign bit_cnt = bit_q;
endmodule

// File: rtl/sclgen_top.sv
module sclgen_top #(
    parameter int CNT_W       = 4,
    parameter int BITS        = 9,
    parameter int SYNC_STAGES = 2,
    localparam int BIT_W      = $clog2(BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] reload,
    input  logic             int_src,
    input  logic             sync_en,
    input  logic             hold_data_en,
    input  logic             hold_ack_en,
    input  logic             stop_rel_en,
    input  logic             xfer_req,
    input  logic             stop_seen,
    output logic             scl_pull_low,
    output logic             shift_clk,
    output logic [BIT_W-1:0] bit_cnt
);
    logic scl_s;
    logic scl_fall;
    logic cnt_zero;
    logic cnt_load;
    logic cnt_dec;
    logic int_clk;
    logic sync_act;

    assign sync_act = sync_en & int_src;

    sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (scl_in),
        .pin_s    (scl_s),
        .pin_fall (scl_fall)
    );

    sclgen_baud #(.W(CNT_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .load   (cnt_load),
        .dec    (cnt_dec),
        .zero   (cnt_zero)
    );

    sclgen_fsm #(.BITS(BITS), .BIT_W(BIT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_req     (xfer_req),
        .stop_seen    (stop_seen),
        .stop_rel_en  (stop_rel_en),
        .sync_act     (sync_act),
        .hold_data_en (hold_data_en),
        .hold_ack_en  (hold_ack_en),
        .pin_s        (scl_s),
        .pin_fall     (scl_fall),
        .cnt_zero     (cnt_zero),
        .cnt_load     (cnt_load),
        .cnt_dec      (cnt_dec),
        .pull_low     (scl_pull_low),
        .int_clk      (int_clk),
        .bit_cnt      (bit_cnt)
    );

    assign shift_clk = int_clk & scl_s;
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk #(
    parameter int BITS  = 9,
    parameter int BIT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_rel_en,
    input logic             stop_seen,
    input logic             scl_pull_low,
    input logic             shift_clk,
    input logic             scl_sync,
    input logic [BIT_W-1:0] bit_cnt
);
    // R8
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(bit_cnt) <= BITS);

    // R8
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt != $past(bit_cnt)) |-> ((32'(bit_cnt) == 32'($past(bit_cnt)) + 1) || (bit_cnt == '0)));

    // R8
    release_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bit_cnt) == 32'($past(bit_cnt)) + 1) |-> (!scl_pull_low && $past(scl_pull_low)));

    // R7
    shift_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |-> scl_sync);

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_rel_en && stop_seen) |=> (!scl_pull_low && (bit_cnt == '0)));
endmodule

bind sclgen_top sclgen_chk #(.BITS(BITS), .BIT_W(BIT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_rel_en  (stop_rel_en),
    .stop_seen    (stop_seen),
    .scl_pull_low (scl_pull_low),
    .shift_clk    (shift_clk),
    .scl_sync     (scl_s),
    .bit_cnt      (bit_cnt)
);

// File: tb/sclgen_top_tb.sv
module sclgen_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_low = 1'b0;
    logic [3:0] reload = 4'd0;
    logic       int_src = 1'b1;
    logic       sync_en = 1'b0;
    logic       hold_data_en = 1'b0;
    logic       hold_ack_en = 1'b0;
    logic       stop_rel_en = 1'b0;
    logic       xfer_req = 1'b0;
    logic       stop_seen = 1'b0;
    logic       scl_pull_low;
    logic       shift_clk;
    logic [3:0] bit_cnt;
    logic       scl_in;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    assign scl_in = ~scl_pull_low & ~ext_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclgen_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_in),
        .reload       (reload),
        .int_src      (int_src),
        .sync_en      (sync_en),
        .hold_data_en (hold_data_en),
        .hold_ack_en  (hold_ack_en),
        .stop_rel_en  (stop_rel_en),
        .xfer_req     (xfer_req),
        .stop_seen    (stop_seen),
        .scl_pull_low (scl_pull_low),
        .shift_clk    (shift_clk),
        .bit_cnt      (bit_cnt)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_frame();
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic wait_state(input int b, input bit d, output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if ((int'(bit_cnt) == b) && (scl_pull_low == d)) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if ((bit_cnt == 4'd0) && !scl_pull_low) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_frame(input int r, input bit se, input bit isrc, input string tag);
        int  lo[16];
        int  hi[16];
        bit  seen9;
        int  exp_lo;
        int  exp_hi;
        for (int i = 0; i < 16; i++) begin
            lo[i] = 0;
            hi[i] = 0;
        end
        @(negedge clk);
        reload  = 4'(r);
        sync_en = se;
        int_src = isrc;
        start_frame();
        seen9 = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            if (scl_pull_low) lo[bit_cnt]++;
            else if (bit_cnt != 4'd0) hi[bit_cnt]++;
            if (bit_cnt == 4'd9) seen9 = 1'b1;
            if (seen9 && (bit_cnt == 4'd0)) break;
            @(negedge clk);
        end
        exp_lo = (se && isrc) ? ((r + 1 > 3) ? r + 1 : 3) : r + 1;
        exp_hi = (se && isrc) ? r + 4 : r + 1;
        for (int k = 0; k < 9; k++) check_eq({tag, " low phase"}, lo[k], exp_lo);
        for (int k = 1; k < 10; k++) check_eq({tag, " high phase"}, hi[k], exp_hi);
        // R8: frame reaches pulse nine then returns to zero
        check_eq("R8 frame end", int'(seen9 && (bit_cnt == 4'd0)), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ok;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 pull", int'(scl_pull_low), 0);
        check_eq("R1 bits", int'(bit_cnt), 0);
        check_eq("R1 shift", int'(shift_clk), 1);

        // R13 idle ignores foreign line activity
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); ext_low = 1'b1;
            repeat (5) @(negedge clk);
            check_eq("R13 idle pull", int'(scl_pull_low), 0);
            ext_low = 1'b0;
            repeat (5) @(negedge clk);
            check_eq("R13 idle bits", int'(bit_cnt), 0);
        end

        // R2 and R3 sweeps over every reload value
        for (int r = 0; r < 16; r++) begin
            run_frame(r, 1'b0, 1'b1, "R2");
            run_frame(r, 1'b1, 1'b1, "R3");
        end
        // R6 synchronization ignored with external source
        run_frame(0, 1'b1, 1'b0, "R6");
        run_frame(5, 1'b1, 1'b0, "R6");
        run_frame(15, 1'b1, 1'b0, "R6");

        // R4, R5, R7 foreign pull-down with synchronization
        @(negedge clk);
        reload = 4'd10; sync_en = 1'b1; int_src = 1'b1;
        start_frame();
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if ((bit_cnt == 4'd3) && !scl_pull_low && shift_clk) begin ok = 1'b1; break; end
        end
        check_eq("R4 reached high", int'(ok), 1);
        ext_low = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_eq("R4 not yet pulled", int'(scl_pull_low), 0);
        @(negedge clk);
        check_eq("R4 pulled on third edge", int'(scl_pull_low), 1);
        repeat (17) @(negedge clk);
        check_eq("R5 released while stretched", int'(scl_pull_low), 0);
        check_eq("R7 shift low while stretched", int'(shift_clk), 0);
        check_eq("R8 count during stretch", int'(bit_cnt), 4);
        ext_low = 1'b0;
        cnt = 0;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            cnt++;
            if (scl_pull_low) break;
        end
        check_eq("R5 restart delay", cnt, 14);
        wait_idle(ok);
        check_eq("R5 frame completes", int'(ok), 1);

        // R6 foreign fall ignored without synchronization
        @(negedge clk);
        sync_en = 1'b0;
        start_frame();
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if ((bit_cnt == 4'd3) && !scl_pull_low && shift_clk) begin ok = 1'b1; break; end
        end
        check_eq("R6 reached high", int'(ok), 1);
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R6 high not shortened", int'(scl_pull_low), 0);
        ext_low = 1'b0;
        wait_idle(ok);
        check_eq("R6 frame completes", int'(ok), 1);

        // R9 stretch after eighth pulse
        @(negedge clk);
        reload = 4'd3; hold_data_en = 1'b1;
        start_frame();
        wait_state(8, 1'b1, ok);
        repeat (40) @(negedge clk);
        check_eq("R9 held low", int'(scl_pull_low), 1);
        check_eq("R9 held count", int'(bit_cnt), 8);
        hold_data_en = 1'b0;
        @(negedge clk);
        check_eq("R9 low phase after resume", int'(scl_pull_low), 1);
        wait_state(9, 1'b0, ok);
        check_eq("R9 ninth pulse", int'(ok), 1);
        wait_idle(ok);
        check_eq("R9 frame completes", int'(ok), 1);

        // R10 stretch after ninth pulse
        @(negedge clk);
        hold_ack_en = 1'b1;
        start_frame();
        wait_state(9, 1'b1, ok);
        check_eq("R10 reached hold", int'(ok), 1);
        repeat (40) @(negedge clk);
        check_eq("R10 held low", int'(scl_pull_low), 1);
        check_eq("R10 held count", int'(bit_cnt), 9);
        hold_ack_en = 1'b0;
        @(negedge clk);
        check_eq("R10 released", int'(scl_pull_low), 0);
        check_eq("R10 count cleared", int'(bit_cnt), 0);

        // R11 stop release
        @(negedge clk);
        reload = 4'd5; stop_rel_en = 1'b1;
        start_frame();
        wait_state(4, 1'b1, ok);
        stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
        check_eq("R11 released", int'(scl_pull_low), 0);
        check_eq("R11 count cleared", int'(bit_cnt), 0);
        cnt = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (scl_pull_low || (bit_cnt != 4'd0)) cnt++;
        end
        check_eq("R11 no further pulses", cnt, 0);

        // R12 stop ignored when release disabled
        @(negedge clk);
        stop_rel_en = 1'b0;
        start_frame();
        wait_state(4, 1'b1, ok);
        stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
        check_eq("R12 count kept", int'(bit_cnt), 4);
        wait_state(9, 1'b0, ok);
        check_eq("R12 ninth pulse", int'(ok), 1);
        wait_idle(ok);
        check_eq("R12 frame completes", int'(ok), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule